// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Option

This block buffers words between two unrelated clock domains. Words enter on the write clock and leave on the read clock. Both pointers cross the domain boundary in Gray code through register synchronizers. There is one storage array and one write side. The read side supports two protocols, and the protocol is chosen when the block comes out of reset.

In standard mode, the consumer must request every word with an active-low read enable. The word then arrives in a registered output one read-clock edge later. In fall-through mode, the output register is filled on its own whenever storage holds a word. The empty output then means that no valid word is on the output bus, and a read enable consumes the word being shown. In this mode the output register adds one word of capacity. The full output means that no room is left: the FIFO is full in standard mode, and input is not ready in fall-through mode.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a rising `wclk_i` edge only when `wen_ni` is low and `full_o` is low. A write attempted while `full_o` is high leaves no trace: the words read out afterwards are exactly those accepted before it, in the same order.
- R2: In standard mode, a rising `rclk_i` edge with `ren_ni` low and `empty_o` low loads the oldest stored word into `rdata_o`. While `ren_ni` is high, `rdata_o` keeps its value.
- R3: In standard mode, `ren_ni` has no effect while `empty_o` is high: `rdata_o` and `empty_o` do not change.
- R4: In standard mode, a word written into an empty FIFO does not appear on `rdata_o` until it is requested with `ren_ni`.
- R5: In both modes, words leave in the order they were accepted, with none lost and none repeated, under independent random enables on both sides.
- R6: With no reads after reset, `full_o` rises after DEPTH accepted writes in standard mode and after DEPTH+1 accepted writes in fall-through mode, once the read side has settled.
- R7: In fall-through mode, the first word written into an empty FIFO appears on `rdata_o`, with `empty_o` low, after the third rising `rclk_i` edge that follows the write edge. No read enable is needed.
- R8: In fall-through mode, `empty_o` rises only on an `rclk_i` edge with `ren_ni` low. After the last word is consumed, that word stays on `rdata_o`. While `ren_ni` is high, the shown word and `empty_o` hold.
- R9: In standard mode, after a write into an empty FIFO, `empty_o` falls after the second rising `rclk_i` edge that follows the write edge.
- R10: When the FIFO is full, `full_o` falls after the second rising `wclk_i` edge that follows the `rclk_i` edge that took a word from storage.
- R11: Reset (`rst_ni` low) is asynchronous and sets `empty_o` high and `full_o` low. The mode is taken from `fwft_mode_i` (1 = fall-through, 0 = standard) on the first rising `rclk_i` edge after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fwft_mode_i | input | 1 | Mode select, 1 = fall-through, taken after reset |
| wen_ni | input | 1 | Active-low write enable |
| wdata_i | input | W | Write data |
| ren_ni | input | 1 | Active-low read enable |
| rdata_o | output | W | Registered read data |
| full_o | output | 1 | No room for a write (write clock domain) |
| empty_o | output | 1 | No word available: storage empty (standard) or no valid output word (fall-through) |

## Verification
The first group of patterns is directed. Single writes into an empty FIFO measure how many read edges pass before the word becomes visible; this tells the two-stage standard flag from the three-stage fall-through path. Fill-to-capacity runs with an extra write attempt show the one-word difference in capacity between the modes and confirm that an overflow write is dropped. A single read from a full FIFO measures how long the full flag takes to release. The second group runs long stretches with random enables on both sides at unrelated clock rates. These runs check the word order and the no-overflow and no-underflow rules against a queue model on every edge.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/xclk_fifo_sync.sv
`timescale 1ns/1ps
module xclk_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
`timescale 1ns/1ps
module xclk_fifo_mem #(
  parameter int AW = 4,
  parameter int W  = 18
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xclk_fifo_wr.sv
`timescale 1ns/1ps
module xclk_fifo_wr #(
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s;

  // full: top two Gray bits inverted, rest equal
  assign full_o   = (wgray_q == {~rgray_s_i[PW-1:PW-2], rgray_s_i[PW-3:0]});
  assign we_o     = ~wen_ni & ~full_o;
  assign wbin_nxt = wbin_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_r2b
    assign rbin_s[i] = ^rgray_s_i[PW-1:i];
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;

  AST_WGRAY_ONE_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R5
  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |=> $stable(wbin_q)); // R1
  AST_WR_OCC_BOUND: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin_s) <= PW'(DEPTH)); // R6
endmodule

// File: rtl/xclk_fifo_rd.sv
`timescale 1ns/1ps
module xclk_fifo_rd
  import xclk_fifo_pkg::*;
#(
  parameter int AW = 4,
  parameter int W  = 18
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ren_ni,
  input  logic [AW:0]   wgray_s_i,
  input  logic [W-1:0]  mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  fifo_mode_e    mode_q;
  logic          mode_ld_q;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_s;
  logic [W-1:0]  rdata_q;
  logic          ovalid_q;
  logic          is_fwft, mem_empty, fetch;

  // mode taken on first edge after reset release
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_STD;
      mode_ld_q <= 1'b1;
    end else if (mode_ld_q) begin
      mode_q    <= fwft_i ? MODE_FWFT : MODE_STD;
      mode_ld_q <= 1'b0;
    end
  end

  assign is_fwft   = (mode_q == MODE_FWFT);
  assign mem_empty = (rgray_q == wgray_s_i);
  assign fetch     = ~mem_empty & (is_fwft ? (~ovalid_q | ~ren_ni) : ~ren_ni);
  assign rbin_nxt  = rbin_q + PW'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else if (fetch) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      rdata_q <= mem_rdata_i;
    end
  end

  // output-valid stage: third register after the two sync flops
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovalid_q <= 1'b0;
    else if (!is_fwft)           ovalid_q <= 1'b0;
    else if (fetch)              ovalid_q <= 1'b1;
    else if (!ren_ni)            ovalid_q <= 1'b0;
  end

  for (genvar i = 0; i < PW; i++) begin : g_w2b
    assign wbin_s[i] = ^wgray_s_i[PW-1:i];
  end

  assign empty_o = is_fwft ? ~ovalid_q : mem_empty;
  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rdata_o = rdata_q;

  AST_RGRAY_ONE_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    mem_empty |=> $stable(rbin_q)); // R3
  AST_STD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!is_fwft && ren_ni) |=> $stable(rdata_q)); // R2
  AST_OR_DROP_ON_READ: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $fell(ovalid_q) |-> ($past(ren_ni) == 1'b0)); // R8
  AST_FWFT_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (is_fwft && ovalid_q && ren_ni) |=> (ovalid_q && $stable(rdata_q))); // R8
  AST_RD_OCC_BOUND: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wbin_s - rbin_q) <= PW'(DEPTH)); // R6
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int AW          = 4,
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         fwft_mode_i,
  input  logic         wen_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         ren_ni,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [W-1:0]  mem_rdata;

  xclk_fifo_wr #(.AW(AW)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .wen_ni    (wen_ni),
    .rgray_s_i (rgray_s),
    .we_o      (we),
    .waddr_o   (waddr),
    .wgray_o   (wgray),
    .full_o    (full_o)
  );

  xclk_fifo_mem #(.AW(AW), .W(W)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  xclk_fifo_rd #(.AW(AW), .W(W)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .fwft_i      (fwft_mode_i),
    .ren_ni      (ren_ni),
    .wgray_s_i   (wgray_s),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o),
    .empty_o     (empty_o)
  );
endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int W     = 18;

  logic         wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic         fwft_mode_i = 1'b0, wen_ni = 1'b1, ren_ni = 1'b1;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         full_o, empty_o;

  int           n_cmp = 0, n_err = 0, rd_count = 0;
  bit           fwft = 1'b0;
  logic [W-1:0] model_q[$];
  logic [W-1:0] last_rd = '0;

  always #2   wclk = ~wclk;
  always #3.3 rclk = ~rclk;

  xclk_fifo #(.AW(AW), .W(W)) u_xclk_fifo (
    .wclk_i      (wclk),
    .rclk_i      (rclk),
    .rst_ni      (rst_ni),
    .fwft_mode_i (fwft_mode_i),
    .wen_ni      (wen_ni),
    .wdata_i     (wdata_i),
    .ren_ni      (ren_ni),
    .rdata_o     (rdata_o),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  // reference model: accepted writes and reads
  always @(negedge rst_ni) begin
    model_q.delete();
    last_rd = '0;
  end

  always @(posedge wclk) begin
    if (rst_ni && !wen_ni && !full_o) model_q.push_back(wdata_i);
  end

  always @(posedge rclk) begin
    if (rst_ni && !ren_ni && !empty_o) begin
      if (model_q.size() == 0) chk(1'b0, "R5 read with model empty", 32'd0, 32'd1);
      else begin
        if (fwft) chk(rdata_o == model_q[0], "R5 fwft consumed word", 32'(rdata_o), 32'(model_q[0]));
        last_rd = model_q.pop_front();
        rd_count++;
      end
    end
  end

  always @(negedge rclk) begin
    if (rst_ni) begin
      if (!fwft) begin
        chk(rdata_o == last_rd, "R2 std output word", 32'(rdata_o), 32'(last_rd));
        if (!empty_o) chk(model_q.size() > 0, "R3 std not empty with no word", 32'(model_q.size()), 32'd1);
      end else if (empty_o) begin
        chk(rdata_o == last_rd, "R8 fwft retained word", 32'(rdata_o), 32'(last_rd));
      end else begin
        chk(model_q.size() > 0, "R7 fwft valid with no word", 32'(model_q.size()), 32'd1);
        if (model_q.size() > 0)
          chk(rdata_o == model_q[0], "R5 fwft shown word", 32'(rdata_o), 32'(model_q[0]));
      end
    end
  end

  always @(negedge wclk) begin
    if (rst_ni && !full_o)
      chk(model_q.size() < (fwft ? DEPTH + 1 : DEPTH), "R1 room when not full",
          32'(model_q.size()), 32'(fwft ? DEPTH + 1 : DEPTH));
  end

  task automatic do_reset(input bit m);
    rst_ni = 1'b0; wen_ni = 1'b1; ren_ni = 1'b1;
    fwft_mode_i = m; fwft = m;
    repeat (3) @(negedge rclk);
    chk(empty_o == 1'b1, "R11 empty in reset", 32'(empty_o), 32'd1);
    chk(full_o == 1'b0, "R11 full in reset", 32'(full_o), 32'd0);
    @(negedge wclk) rst_ni = 1'b1;
    repeat (4) @(negedge rclk);
    chk(empty_o == 1'b1, "R11 empty after reset", 32'(empty_o), 32'd1);
    chk(full_o == 1'b0, "R11 full after reset", 32'(full_o), 32'd0);
  endtask

  task automatic settle();
    repeat (12) @(negedge wclk);
  endtask

  task automatic write_one(input logic [W-1:0] d);
    @(negedge wclk) begin wen_ni = 1'b0; wdata_i = d; end
    @(negedge wclk) wen_ni = 1'b1;
  endtask

  task automatic read_one();
    @(negedge rclk) ren_ni = 1'b0;
    @(negedge rclk) ren_ni = 1'b1;
  endtask

  // read-clock edges after the write edge until empty_o drops
  task automatic write_timed(input logic [W-1:0] d, output int n);
    realtime tw;
    @(negedge wclk) begin wen_ni = 1'b0; wdata_i = d; end
    @(posedge wclk) tw = $realtime;
    fork begin @(negedge wclk) wen_ni = 1'b1; end join_none
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge rclk) if ($realtime != tw) n++;
      @(negedge rclk) if (!empty_o) break;
    end
  endtask

  // write-clock edges after the read edge until full_o drops
  task automatic read_timed(output int n);
    realtime tr;
    @(negedge rclk) ren_ni = 1'b0;
    @(posedge rclk) tr = $realtime;
    fork begin @(negedge rclk) ren_ni = 1'b1; end join_none
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge wclk) if ($realtime != tr) n++;
      @(negedge wclk) if (!full_o) break;
    end
  endtask

  task automatic drain();
    @(negedge rclk) ren_ni = 1'b0;
    for (int k = 0; k < 4 * DEPTH + 10; k++) begin
      @(negedge rclk) if (empty_o) break;
    end
    ren_ni = 1'b1;
  endtask

  task automatic overflow_try();
    @(negedge wclk) begin wen_ni = 1'b0; wdata_i = '1; end
    repeat (3) @(negedge wclk);
    wen_ni = 1'b1;
  endtask

  task automatic stress(input int n_words, input logic [W-1:0] base);
    int target;
    target = rd_count + n_words;
    fork
      begin
        int seq = 0;
        while (seq < n_words) begin
          @(negedge wclk) begin
            wen_ni  = (($urandom % 3) == 0);
            wdata_i = base + W'(seq);
          end
          @(posedge wclk) if (!wen_ni && !full_o) seq++;
        end
        @(negedge wclk) wen_ni = 1'b1;
      end
      begin
        forever begin
          @(negedge rclk);
          if (rd_count >= target) break;
          ren_ni = (($urandom % 4) == 0);
        end
        ren_ni = 1'b1;
      end
    join
    settle();
    chk(model_q.size() == 0, "R5 all words drained", 32'(model_q.size()), 32'd0);
    chk(rd_count == target, "R5 read count", 32'(rd_count), 32'(target));
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_cmp++; n_err++;
    $display("FAIL R5 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    int n, base;

    // ---------------- standard mode ----------------
    do_reset(1'b0);
    write_timed(18'h1A5, n);
    chk(n == 2, "R9 empty release latency", 32'(n), 32'd2);
    repeat (10) @(negedge rclk);
    chk(rdata_o == '0, "R4 word not shown unrequested", 32'(rdata_o), 32'd0);
    chk(empty_o == 1'b0, "R4 word pending", 32'(empty_o), 32'd0);
    read_one();
    chk(rdata_o == 18'h1A5, "R2 requested word", 32'(rdata_o), 32'h1A5);
    chk(empty_o == 1'b1, "R2 empty after last", 32'(empty_o), 32'd1);
    @(negedge rclk) ren_ni = 1'b0;
    repeat (3) @(negedge rclk);
    ren_ni = 1'b1;
    chk(rdata_o == 18'h1A5, "R3 read while empty", 32'(rdata_o), 32'h1A5);
    chk(empty_o == 1'b1, "R3 still empty", 32'(empty_o), 32'd1);

    for (int i = 0; i < DEPTH - 1; i++) write_one(W'(i));
    settle();
    chk(full_o == 1'b0, "R6 std not full at DEPTH-1", 32'(full_o), 32'd0);
    write_one(W'(DEPTH - 1));
    settle();
    chk(full_o == 1'b1, "R6 std full at DEPTH", 32'(full_o), 32'd1);
    overflow_try();
    chk(full_o == 1'b1, "R1 full after overflow try", 32'(full_o), 32'd1);
    base = rd_count;
    read_timed(n);
    chk(n == 2, "R10 full release latency", 32'(n), 32'd2);
    drain();
    chk(rd_count - base == DEPTH, "R1 std words out", 32'(rd_count - base), 32'(DEPTH));
    chk(last_rd == W'(DEPTH - 1), "R1 std last word", 32'(last_rd), 32'(DEPTH - 1));
    stress(300, 18'h10000);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    write_timed(18'h2B7, n);
    chk(n == 3, "R7 first word latency", 32'(n), 32'd3);
    chk(rdata_o == 18'h2B7, "R7 first word shown", 32'(rdata_o), 32'h2B7);
    repeat (6) @(negedge rclk);
    chk(empty_o == 1'b0, "R8 valid holds", 32'(empty_o), 32'd0);
    chk(rdata_o == 18'h2B7, "R8 word holds", 32'(rdata_o), 32'h2B7);
    read_one();
    chk(empty_o == 1'b1, "R8 not ready after read", 32'(empty_o), 32'd1);
    chk(rdata_o == 18'h2B7, "R8 last word retained", 32'(rdata_o), 32'h2B7);

    write_one(18'd100);
    settle();
    for (int i = 1; i < DEPTH; i++) write_one(W'(100 + i));
    settle();
    chk(full_o == 1'b0, "R6 fwft not full at DEPTH", 32'(full_o), 32'd0);
    write_one(W'(100 + DEPTH));
    settle();
    chk(full_o == 1'b1, "R6 fwft full at DEPTH+1", 32'(full_o), 32'd1);
    overflow_try();
    base = rd_count;
    drain();
    chk(rd_count - base == DEPTH + 1, "R1 fwft words out", 32'(rd_count - base), 32'(DEPTH + 1));
    chk(last_rd == W'(100 + DEPTH), "R1 fwft last word", 32'(last_rd), 32'(100 + DEPTH));
    stress(300, 18'h20000);

    finish_run();
  end
endmodule